// File: doc/BRIEF.md
# Per-Core Banked Timer Address Router

This block sits between a register bus and a bank of countdown timers for a cluster of up to four cores. Each core owns two countdown instances: a general timer and a watchdog. The bus address space is cut into windows of 32 bytes. The two lowest windows are aliases. They resolve to the timer or watchdog of whichever core issues the access, as named on a core-identifier sideband. Every higher pair of windows addresses one specific core's timer and watchdog directly, so any core can reach any instance.

Every request is accepted in the cycle it is presented, and `req_ready` is held high. Exactly one response follows in the next cycle. It carries read data or an error flag, and `rsp_valid` has no back-pressure: the requester must take the response in that cycle. The following are errors that have no side effects: an access with the wrong size or alignment, an alias access from a core identifier that has no instances, and an access to a window beyond the last populated one. Each countdown instance drives one interrupt line. The lines are collected into a vector ordered by core, with the timer before the watchdog. A core count outside 1 to 4 stops elaboration.

Top module: `mpt_router`

## Requirements
- R1: An access to window 0 (address bits [ADDR_W-1:5] equal to 0) reaches the timer of the core named on `req_core`.
- R2: An access to window 1 reaches the watchdog of the core named on `req_core`.
- R3: Window 2+2k reaches core k's timer and window 3+2k reaches core k's watchdog, for k from 0 to NUM_CORES-1, whatever the value of `req_core`.
- R4: An access to window 0 or 1 with `req_core` >= NUM_CORES returns an error, and a write of this kind changes no instance.
- R5: An access whose `req_size` is not 2 (a 32-bit word), or whose address bits [1:0] are not 0, returns an error and changes no instance.
- R6: An access to a window above 2*NUM_CORES+1 returns an error.
- R7: An error response has `rsp_valid` and `rsp_err` high for one cycle, with `rsp_rdata` equal to 0.
- R8: `req_ready` is always 1. Each accepted request gives `rsp_valid` exactly one cycle later, and no response appears without a request. Writes return `rsp_rdata` = 0.
- R9: Interrupt bit 2k belongs to core k's timer and bit 2k+1 to core k's watchdog.
- R10: Register layout within a window: offset 0x0 is the reload value, 0x4 the counter, 0x8 the control and 0xC the status. Control bit 0 enables the instance, bit 1 selects automatic reload, and bits [8+PRE_W-1:8] hold a prescale P. While the instance is enabled and the counter is not zero, the counter falls by one every P+1 cycles. When the counter would reach zero, status bit 0 is set, and the counter either takes the reload value (automatic reload) or stays at 0.
- R11: Writing 1 to status bit 0 clears it, and the instance's interrupt line, which mirrors that bit, falls. A status set in the same cycle takes precedence.
- R12: Writing the reload value also loads the counter. The counter reads as 0 while the instance is disabled. Offsets 0x10 to 0x1C read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1; the request is taken in the cycle it is presented |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address; bits above 4 select the window |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| req_core | input | 2 | Identifier of the requesting core |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data; 0 on writes and errors |
| irq | output | 2*NUM_CORES | Interrupt per instance, timer then watchdog per core |

## Verification
On every cycle, the checker confirms these rules: a response follows each request and only a request; error responses carry zero data; a request with a bad size, a bad alignment, an unpopulated alias core or a window beyond the last one gets an error response; and an interrupt line falls only after a write. Only the bench scenarios can show that an access lands in the correct instance, that rejected writes leave every instance unchanged, and that the counting is exact. The counting covers the prescaled tick spacing, one-shot stop against automatic reload, and the cycle in which each interrupt rises.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  localparam int MAX_CORES  = 4;
  localparam int INST_IDX_W = 3;
  localparam int DATA_W     = 32;
  localparam int WIN_BYTES_LG = 5;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [1:0] {
    REG_RELOAD  = 2'd0,
    REG_COUNTER = 2'd1,
    REG_CONTROL = 2'd2,
    REG_STATUS  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic                  err;
    logic [INST_IDX_W-1:0] inst;
  } route_t;
endpackage

// File: rtl/mpt_window_decode.sv
module mpt_window_decode
  import mpt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [1:0]        core,
  output route_t            route
);
  localparam int WIN_W = ADDR_W - WIN_BYTES_LG;
  localparam logic [WIN_W-1:0] LAST_WIN  = WIN_W'(2 * NUM_CORES + 1);
  localparam logic [WIN_W-1:0] FIRST_DIR = WIN_W'(2);
  localparam logic [2:0]       CORE_LIM  = 3'(NUM_CORES);

  logic [WIN_W-1:0] win;
  logic             bad_shape;
  logic             alias_hit;
  logic             alias_bad;
  logic [WIN_W-1:0] direct_off;

  assign win        = addr[ADDR_W-1:WIN_BYTES_LG];
  assign bad_shape  = (size != SIZE_WORD) || (addr[1:0] != 2'b00);
  assign alias_hit  = (win < FIRST_DIR);
  assign alias_bad  = ({1'b0, core} >= CORE_LIM);
  assign direct_off = win - FIRST_DIR;

  always_comb begin
    route.err  = bad_shape;
    route.inst = '0;
    if (alias_hit) begin
      route.inst = INST_IDX_W'({core, win[0]});
      if (alias_bad) route.err = 1'b1;
    end else if (win <= LAST_WIN) begin
      route.inst = INST_IDX_W'(direct_off);
    end else begin
      route.err = 1'b1;
    end
  end
endmodule

// File: rtl/mpt_count_unit.sv
module mpt_count_unit
  import mpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              off_high,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [CNT_W-1:0] reload_q, count_q;
  logic [PRE_W-1:0] scale_q, pre_q;
  logic             en_q, auto_q, flag_q;
  logic             wr_live, tick, expire;

  assign wr_live = wr_en && !off_high;
  assign tick    = en_q && (count_q != '0) && (pre_q == scale_q);
  assign expire  = tick && (count_q == CNT_W'(1));
  assign irq     = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      scale_q  <= '0;
      pre_q    <= '0;
      en_q     <= 1'b0;
      auto_q   <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (en_q && (count_q != '0)) begin
        if (tick) begin
          pre_q <= '0;
          if (expire) count_q <= auto_q ? reload_q : '0;
          else        count_q <= count_q - CNT_W'(1);
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
      if (wr_live) begin
        unique case (sel)
          REG_RELOAD: begin
            reload_q <= wdata[CNT_W-1:0];
            count_q  <= wdata[CNT_W-1:0];
            pre_q    <= '0;
          end
          REG_COUNTER: begin
            count_q <= wdata[CNT_W-1:0];
            pre_q   <= '0;
          end
          REG_CONTROL: begin
            en_q    <= wdata[0];
            auto_q  <= wdata[1];
            scale_q <= wdata[8 +: PRE_W];
            if (!en_q && wdata[0]) begin
              pre_q <= '0;
              if ((count_q == '0) && wdata[1]) count_q <= reload_q;
            end
          end
          REG_STATUS: if (wdata[0]) flag_q <= 1'b0;
          default: ;
        endcase
      end
      if (expire) flag_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (!off_high) begin
      unique case (sel)
        REG_RELOAD:  rdata = DATA_W'(reload_q);
        REG_COUNTER: rdata = en_q ? DATA_W'(count_q) : '0;
        REG_CONTROL: begin
          rdata[0]          = en_q;
          rdata[1]          = auto_q;
          rdata[8 +: PRE_W] = scale_q;
        end
        REG_STATUS:  rdata[0] = flag_q;
        default:     rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mpt_router.sv
module mpt_router
  import mpt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 32,
  parameter int PRE_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_size,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [1:0]             req_core,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [2*NUM_CORES-1:0] irq
);
  localparam int NUM_INST = 2 * NUM_CORES;

  if ((NUM_CORES < 1) || (NUM_CORES > MAX_CORES)) begin : g_bad_cores
    $error("mpt_router: NUM_CORES must lie between 1 and 4");
  end

  route_t            route;
  reg_sel_e          sel;
  logic              off_high;
  logic [DATA_W-1:0] unit_rdata [NUM_INST];
  logic [DATA_W-1:0] pick_rdata;

  assign req_ready = 1'b1;
  assign sel       = reg_sel_e'(req_addr[3:2]);
  assign off_high  = req_addr[4];

  mpt_window_decode #(
    .NUM_CORES(NUM_CORES),
    .ADDR_W   (ADDR_W)
  ) decode_i (
    .addr (req_addr),
    .size (req_size),
    .core (req_core),
    .route(route)
  );

  for (genvar i = 0; i < NUM_INST; i++) begin : g_inst
    logic hit;
    assign hit = req_valid && !route.err && (route.inst == INST_IDX_W'(i));
    mpt_count_unit #(
      .CNT_W(CNT_W),
      .PRE_W(PRE_W)
    ) unit_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (hit && req_write),
      .off_high(off_high),
      .sel     (sel),
      .wdata   (req_wdata),
      .rdata   (unit_rdata[i]),
      .irq     (irq[i])
    );
  end

  always_comb begin
    pick_rdata = '0;
    for (int i = 0; i < NUM_INST; i++) begin
      if (route.inst == INST_IDX_W'(i)) pick_rdata = unit_rdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && route.err;
      rsp_rdata <= (req_valid && !route.err && !req_write) ? pick_rdata : '0;
    end
  end
endmodule

// File: rtl/mpt_router_chk.sv
module mpt_router_chk
  import mpt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [ADDR_W-1:0]      req_addr,
  input logic [1:0]             req_size,
  input logic [1:0]             req_core,
  input logic                   rsp_valid,
  input logic                   rsp_err,
  input logic [DATA_W-1:0]      rsp_rdata,
  input logic [2*NUM_CORES-1:0] irq
);
  localparam int WIN_W = ADDR_W - WIN_BYTES_LG;
  logic [WIN_W-1:0] win;
  assign win = req_addr[ADDR_W-1:WIN_BYTES_LG];

  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_err_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
  assert_err_has_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  assert_bad_shape_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_size != 2'd2) || (req_addr[1:0] != 2'b00))) |=> rsp_err);
  assert_alias_core_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (int'(win) < 2) && (int'(req_core) >= NUM_CORES)) |=> rsp_err);
  assert_high_window_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (int'(win) > 2 * NUM_CORES + 1)) |=> rsp_err);

  for (genvar i = 0; i < 2 * NUM_CORES; i++) begin : g_irq
    assert_irq_fall_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[i]) |-> $past(req_valid && req_write));
  end
endmodule

bind mpt_router mpt_router_chk #(
  .NUM_CORES(NUM_CORES),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_size (req_size),
  .req_core (req_core),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err),
  .rsp_rdata(rsp_rdata),
  .irq      (irq)
);

// File: tb/mpt_router_tb.sv
module mpt_router_tb_top;
  localparam int N  = 2;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd2;
  logic [31:0]   req_wdata = '0;
  logic [1:0]    req_core = '0;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic [2*N-1:0] irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [31:0] d; logic e; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  mpt_router #(.NUM_CORES(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .req_core(req_core), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input int win, input int off, input logic [31:0] wd,
                     input logic [1:0] cid, input logic [31:0] ed, input logic ee,
                     input string tag, input logic [1:0] sz = 2'd2, input int bump = 0);
    exp_t item;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'((win << 5) + off + bump);
    req_size  = sz;
    req_wdata = wd;
    req_core  = cid;
    item.d = ed; item.e = ee; item.tag = tag;
    sb.push_back(item);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 response without request", 32'(rsp_valid), 32'd0);
      end else begin
        exp_t item;
        item = sb.pop_front();
        check(rsp_err == item.e, {item.tag, " err"}, 32'(rsp_err), 32'(item.e));
        check(rsp_rdata == item.d, {item.tag, " data"}, rsp_rdata, item.d);
      end
    end
  end

  task automatic irq_is(input logic [2*N-1:0] e, input string tag);
    check(irq == e, tag, 32'(irq), 32'(e));
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check(req_ready == 1'b1, "R8 ready high", 32'(req_ready), 32'd1);
    irq_is('0, "R9 reset irq");

    // R3 direct windows: 2=t0 3=w0 4=t1 5=w1
    acc(1, 4, 0, 32'h11, 0, 0, 0, "R3 write t1 load");
    acc(0, 2, 0, 0, 0, 32'h0, 0, "R3 t0 untouched");
    acc(0, 4, 0, 0, 3, 32'h11, 0, "R3 read t1 load");
    acc(1, 5, 0, 32'h22, 0, 0, 0, "R3 write w1 load");
    acc(0, 3, 0, 0, 0, 32'h0, 0, "R3 w0 untouched");
    acc(0, 5, 0, 0, 0, 32'h22, 0, "R3 read w1 load");
    // R1 alias timer
    acc(0, 0, 0, 0, 1, 32'h11, 0, "R1 alias core1 timer");
    acc(0, 0, 0, 0, 0, 32'h0, 0, "R1 alias core0 timer");
    acc(1, 0, 0, 32'h33, 0, 0, 0, "R1 alias write core0");
    acc(0, 2, 0, 0, 1, 32'h33, 0, "R1 landed in t0");
    // R2 alias watchdog
    acc(0, 1, 0, 0, 1, 32'h22, 0, "R2 alias core1 wdog");
    acc(1, 1, 0, 32'h44, 0, 0, 0, "R2 alias write core0");
    acc(0, 3, 0, 0, 1, 32'h44, 0, "R2 landed in w0");
    // R4 bad core on alias
    acc(1, 0, 0, 32'h99, 2, 0, 1, "R4 write core2");
    acc(0, 1, 0, 0, 3, 0, 1, "R4 read core3");
    acc(0, 2, 0, 0, 0, 32'h33, 0, "R4 t0 kept");
    acc(0, 4, 0, 0, 0, 32'h11, 0, "R4 t1 kept");
    acc(0, 1, 0, 0, 0, 32'h44, 0, "R4 w0 kept");
    // R5 size and alignment
    acc(1, 2, 0, 32'h77, 0, 0, 1, "R5 halfword write", 2'd1);
    acc(0, 2, 0, 0, 0, 0, 1, "R5 byte read", 2'd0);
    acc(1, 2, 0, 32'h78, 0, 0, 1, "R5 unaligned write", 2'd2, 1);
    acc(0, 2, 0, 0, 0, 32'h33, 0, "R5 t0 kept");
    // R6 windows beyond the last
    acc(0, 6, 0, 0, 0, 0, 1, "R6 read window6");
    acc(1, 7, 0, 32'h5, 0, 0, 1, "R6 write window7");
    // R12 register map corners
    acc(0, 2, 4, 0, 0, 32'h0, 0, "R12 counter disabled reads 0");
    acc(0, 2, 8, 0, 0, 32'h0, 0, "R12 control reset");
    acc(1, 2, 16, 32'hFF, 0, 0, 0, "R12 write high offset");
    acc(0, 2, 16, 0, 0, 32'h0, 0, "R12 high offset reads 0");
    acc(0, 2, 0, 0, 0, 32'h33, 0, "R12 load kept after high write");
    // R10 running count, prescale 0
    acc(1, 2, 0, 32'd100, 0, 0, 0, "R10 load 100");
    acc(1, 2, 8, 32'h1, 0, 0, 0, "R10 enable");
    acc(0, 2, 4, 0, 0, 32'd100, 0, "R10 count first");
    acc(0, 2, 4, 0, 0, 32'd99, 0, "R10 count second");
    acc(1, 2, 8, 32'h0, 0, 0, 0, "R10 disable");
    acc(0, 2, 4, 0, 0, 32'd0, 0, "R12 disabled count 0");
    acc(0, 2, 8, 0, 0, 32'h0, 0, "R10 control readback");
    // R10/R9 one-shot expiry on w1 (irq bit 3)
    acc(1, 5, 0, 32'd5, 0, 0, 0, "R10 w1 load 5");
    acc(1, 5, 8, 32'h1, 0, 0, 0, "R10 w1 enable");
    repeat (4) @(posedge clk);
    @(negedge clk); irq_is('0, "R10 no irq before expiry");
    @(posedge clk);
    @(negedge clk); irq_is(4'b1000, "R9 w1 irq on bit3");
    acc(0, 5, 4, 0, 0, 32'd0, 0, "R10 one-shot stops at 0");
    acc(0, 5, 12, 0, 0, 32'd1, 0, "R10 status set");
    acc(1, 5, 12, 32'h1, 0, 0, 0, "R11 clear status");
    @(negedge clk); irq_is('0, "R11 irq cleared");
    acc(1, 5, 8, 32'h0, 0, 0, 0, "R10 w1 disable");
    // R10 prescale 1 on t1 (irq bit 2)
    acc(1, 4, 0, 32'd2, 0, 0, 0, "R10 t1 load 2");
    acc(1, 4, 8, 32'h101, 0, 0, 0, "R10 t1 enable prescale1");
    repeat (3) @(posedge clk);
    @(negedge clk); irq_is('0, "R10 prescale holds expiry");
    @(posedge clk);
    @(negedge clk); irq_is(4'b0100, "R9 t1 irq on bit2");
    acc(1, 4, 8, 32'h0, 0, 0, 0, "R10 t1 disable");
    acc(1, 4, 12, 32'h1, 0, 0, 0, "R11 t1 clear");
    @(negedge clk); irq_is('0, "R11 t1 irq cleared");
    // R10 automatic reload on t0 (irq bit 0)
    acc(1, 2, 0, 32'd3, 0, 0, 0, "R10 t0 load 3");
    acc(1, 2, 8, 32'h3, 0, 0, 0, "R10 t0 enable reload");
    repeat (2) @(posedge clk);
    @(negedge clk); irq_is('0, "R10 reload before expiry");
    @(posedge clk);
    @(negedge clk); irq_is(4'b0001, "R9 t0 irq on bit0");
    acc(0, 2, 4, 0, 0, 32'd2, 0, "R10 reloaded and counting");
    acc(1, 2, 8, 32'h0, 0, 0, 0, "R10 t0 disable");
    acc(1, 2, 12, 32'h1, 0, 0, 0, "R11 t0 clear");
    @(negedge clk); irq_is('0, "R11 t0 irq cleared");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R8 responses outstanding", 32'(sb.size()), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule